// File: doc/BRIEF.md
# Configurable SPI Master Channel

This block is the serial engine of one SPI master channel. A configuration word and a transmit word are presented at its inputs. A one-cycle start strobe latches both and runs a single transfer. The block lowers an active-low chip select and waits a programmable guard time. It then clocks out the word MSB first on MOSI while it samples MISO. After a second guard time it raises chip select again and holds it high for a recovery interval before it accepts another start.

The serial clock timing comes from a half-period divider. A half-period is H reference-clock cycles, where H is either a power of two or a linear 12-bit value plus one, chosen by a granularity bit. The word length runs from 4 to 32 bits. The direction can be full duplex, receive only or transmit only. Each received word is presented right-aligned on `rx_data` together with a one-cycle `rx_valid` pulse.

The controller is a five-state machine:
- ST_IDLE: chip select high, waiting for start.
- ST_LEAD: chip select low, leading guard.
- ST_SHIFT: serial clock toggling.
- ST_TRAIL: chip select still low, trailing guard.
- ST_GAP: chip select high, recovery.

The transitions are:
- ST_IDLE to ST_LEAD on an accepted start.
- ST_LEAD to ST_SHIFT when the leading guard ends. This tick is also the first rising edge.
- ST_SHIFT to ST_TRAIL on the last falling edge.
- ST_TRAIL to ST_GAP when the trailing guard ends. Chip select rises here.
- ST_GAP to ST_IDLE after two half-periods.

Top module: `spi_master_chan`

## Requirements
- R1: A length code c in 3..31 on `cfg_wlen` produces exactly c+1 rising SCLK edges per transfer, with data moved MSB first in both directions.
- R2: A start strobe is ignored when the length code is 0, 1 or 2, or when the mode code on `cfg_mode` is 3. In that case `busy` stays low and `cs_n` stays high.
- R3: The interval from the falling edge of `cs_n` to the first rising SCLK edge is (2g+1)·H reference cycles, where g is `cfg_guard`.
- R4: The interval from the last falling SCLK edge to the rising edge of `cs_n` is (2g+1)·H reference cycles.
- R5: With `cfg_lin` = 0, H = 2^n, where n is `cfg_div`.
- R6: With `cfg_lin` = 1, H = {`cfg_ext`,`cfg_div`} + 1, which treats the two fields as one 12-bit value.
- R7: Mode code 0 is full duplex. MOSI carries the low c+1 bits of `tx_data` and changes only after falling SCLK edges. MISO is sampled on rising edges. The received word appears on `rx_data` with its upper bits zero, together with a `rx_valid` pulse one cycle long.
- R8: Mode code 1 is receive only. MOSI stays low for the whole transfer, and the received word is still reported with `rx_valid`.
- R9: Mode code 2 is transmit only. MOSI carries the word, and `rx_valid` is never raised.
- R10: After each word, `cs_n` stays high for 2·H reference cycles before `busy` falls. A start strobe while `busy` is high is ignored, as are any configuration changes at that time.
- R11: `busy` rises in the cycle after an accepted start and is high for the whole transfer. SCLK is low whenever `cs_n` is high.
- R12: After reset, `cs_n` = 1, `sclk` = 0, `mosi` = 0, `busy` = 0 and `rx_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle transfer request |
| cfg_wlen | input | 5 | Word length code (bits = code+1) |
| cfg_mode | input | 2 | 0 duplex, 1 receive only, 2 transmit only, 3 reserved |
| cfg_guard | input | 2 | Chip-select guard code g |
| cfg_lin | input | 1 | Divider granularity: 0 power of two, 1 linear |
| cfg_div | input | 4 | Divider code / low bits of linear divisor |
| cfg_ext | input | 8 | High bits of linear divisor |
| tx_data | input | 32 | Word to send, right-aligned |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low chip select |
| rx_data | output | 32 | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |
| busy | output | 1 | High from the cycle after start until back to idle |

## Verification
Two functions can fall in the same reference cycle: a new start strobe and a transfer that is still running. The bench provokes this by pulsing `start` in the middle of a word, with a different length, mode and transmit word on the inputs. It judges the result by counting chip-select falls and by comparing the serial word, the edge count and the timings against the values computed from the original configuration. At a divide ratio of 1, every reference edge is also an SCLK edge. The ST_LEAD exit and the first rising edge then share one cycle, and the trailing guard starts on the same edge that raises `rx_valid`. A full sweep of length, mode and guard at H = 1 exercises these coincidences at every length code.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;

    localparam int unsigned WLEN_W  = 5;
    localparam int unsigned MODE_W  = 2;
    localparam int unsigned DIV_W   = 4;
    localparam int unsigned EXT_W   = 8;
    localparam int unsigned GUARD_W = 2;

    typedef enum logic [MODE_W-1:0] {
        XFER_DUPLEX  = 2'd0,
        XFER_RX_ONLY = 2'd1,
        XFER_TX_ONLY = 2'd2,
        XFER_RSVD    = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_GAP
    } chan_state_e;

    typedef struct packed {
        logic [WLEN_W-1:0]  wlen;
        xfer_mode_e         mode;
        logic [GUARD_W-1:0] guard;
        logic               lin;
        logic [DIV_W-1:0]   div;
        logic [EXT_W-1:0]   ext;
    } chan_cfg_t;

endpackage

// File: rtl/spi_half_div.sv
module spi_half_div #(
    parameter int unsigned DIV_W = 4,
    parameter int unsigned EXT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             lin,
    input  logic [DIV_W-1:0] div,
    input  logic [EXT_W-1:0] ext,
    output logic             tick
);
    localparam int unsigned POW_W = 2 ** DIV_W;
    localparam int unsigned LIN_W = DIV_W + EXT_W + 1;
    localparam int unsigned CNT_W = (POW_W > LIN_W) ? POW_W : LIN_W;

    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] cnt;

    // half-period length in reference cycles
    always_comb begin
        if (lin) begin
            ratio = CNT_W'({ext, div}) + CNT_W'(1);
        end else begin
            ratio = CNT_W'(1) << div;
        end
    end

    assign tick = en && (cnt == ratio - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WLEN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [WLEN_W-1:0] wlen,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              miso,
    output logic              tx_msb,
    output logic [DATA_W-1:0] rx_word
);
    localparam logic [WLEN_W:0] TOP_IDX = (WLEN_W + 1)'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [WLEN_W:0]   align;

    // left-justify the active bits so the word's MSB sits at the top
    assign align = TOP_IDX - {1'b0, wlen};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else if (load) begin
            tx_sh <= tx_word << align;
            rx_sh <= '0;
        end else begin
            if (shift_en) begin
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
            if (sample_en) begin
                rx_sh <= {rx_sh[DATA_W-2:0], miso};
            end
        end
    end

    assign tx_msb  = tx_sh[DATA_W-1];
    assign rx_word = rx_sh;
endmodule

// File: rtl/spi_master_chan.sv
module spi_master_chan
    import spi_chan_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WLEN_W-1:0]  cfg_wlen,
    input  logic [MODE_W-1:0]  cfg_mode,
    input  logic [GUARD_W-1:0] cfg_guard,
    input  logic               cfg_lin,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [EXT_W-1:0]   cfg_ext,
    input  logic [DATA_W-1:0]  tx_data,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_valid,
    output logic               busy
);
    localparam int unsigned HC_W = $clog2(2 * DATA_W) + 1;

    chan_state_e state_q, state_d;
    chan_cfg_t   cfg_q;
    logic [HC_W-1:0] hcnt;
    logic        tick;
    logic        cfg_ok, go;
    logic        lead_done, shift_done, trail_done, gap_done;
    logic        sample_en, shift_en, tx_msb;
    logic [DATA_W-1:0] rx_word;
    xfer_mode_e  act_mode;

    assign act_mode   = cfg_q.mode;
    assign cfg_ok     = (cfg_wlen >= WLEN_W'(3)) && (xfer_mode_e'(cfg_mode) != XFER_RSVD);
    assign go         = (state_q == ST_IDLE) && start && cfg_ok;
    assign lead_done  = tick && (hcnt == HC_W'({cfg_q.guard, 1'b0}));
    assign shift_done = tick && (hcnt == HC_W'({cfg_q.wlen, 1'b1}));
    assign trail_done = lead_done;
    assign gap_done   = tick && (hcnt == HC_W'(1));

    assign sample_en  = ((state_q == ST_LEAD) && lead_done) ||
                        ((state_q == ST_SHIFT) && tick && !hcnt[0]);
    assign shift_en   = (state_q == ST_SHIFT) && tick && hcnt[0] && !shift_done;

    assign busy = (state_q != ST_IDLE);
    assign mosi = !cs_n && (act_mode != XFER_RX_ONLY) && tx_msb;

    spi_half_div #(.DIV_W(DIV_W), .EXT_W(EXT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .lin   (cfg_q.lin),
        .div   (cfg_q.div),
        .ext   (cfg_q.ext),
        .tick  (tick)
    );

    spi_word_shifter #(.DATA_W(DATA_W), .WLEN_W(WLEN_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go),
        .tx_word   (tx_data),
        .wlen      (cfg_wlen),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .miso      (miso),
        .tx_msb    (tx_msb),
        .rx_word   (rx_word)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go)         state_d = ST_LEAD;
            ST_LEAD:  if (lead_done)  state_d = ST_SHIFT;
            ST_SHIFT: if (shift_done) state_d = ST_TRAIL;
            ST_TRAIL: if (trail_done) state_d = ST_GAP;
            ST_GAP:   if (gap_done)   state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs, edge counter and latched configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk     <= 1'b0;
            cs_n     <= 1'b1;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            hcnt     <= '0;
            cfg_q    <= '0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    hcnt <= '0;
                    sclk <= 1'b0;
                    if (go) begin
                        cs_n  <= 1'b0;
                        cfg_q <= '{wlen: cfg_wlen, mode: xfer_mode_e'(cfg_mode),
                                   guard: cfg_guard, lin: cfg_lin,
                                   div: cfg_div, ext: cfg_ext};
                    end
                end
                ST_LEAD: if (tick) begin
                    if (lead_done) begin
                        hcnt <= HC_W'(1);
                        sclk <= 1'b1;
                    end else begin
                        hcnt <= hcnt + HC_W'(1);
                    end
                end
                ST_SHIFT: if (tick) begin
                    if (hcnt[0]) begin
                        sclk <= 1'b0;
                        if (shift_done) begin
                            hcnt <= '0;
                            if (act_mode != XFER_TX_ONLY) begin
                                rx_valid <= 1'b1;
                                rx_data  <= rx_word;
                            end
                        end else begin
                            hcnt <= hcnt + HC_W'(1);
                        end
                    end else begin
                        sclk <= 1'b1;
                        hcnt <= hcnt + HC_W'(1);
                    end
                end
                ST_TRAIL: if (tick) begin
                    if (trail_done) begin
                        cs_n <= 1'b1;
                        hcnt <= '0;
                    end else begin
                        hcnt <= hcnt + HC_W'(1);
                    end
                end
                ST_GAP: if (tick) begin
                    hcnt <= hcnt + HC_W'(1);
                end
                default: begin
                    hcnt <= '0;
                    sclk <= 1'b0;
                    cs_n <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_master_chan_chk.sv
module spi_master_chan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [4:0] cfg_wlen,
    input logic [1:0] cfg_mode,
    input logic [1:0] act_mode,
    input logic       busy,
    input logic       cs_n,
    input logic       sclk,
    input logic       mosi,
    input logic       rx_valid
);
    assert_reserved_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && ((cfg_wlen < 5'd3) || (cfg_mode == 2'd3))) |=> !busy);

    assert_rxonly_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && act_mode == 2'd1) |-> !mosi);

    assert_txonly_novalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (act_mode != 2'd2));

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_valid_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !cs_n);

    assert_cs_high_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    assert_sclk_parked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_busy_from_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind spi_master_chan spi_master_chan_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_wlen (cfg_wlen),
    .cfg_mode (cfg_mode),
    .act_mode (act_mode),
    .busy     (busy),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .rx_valid (rx_valid)
);

// File: tb/spi_master_chan_test.sv
`timescale 1ns/1ps
module spi_master_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  cfg_wlen = '0;
    logic [1:0]  cfg_mode = '0;
    logic [1:0]  cfg_guard = '0;
    logic        cfg_lin = 1'b0;
    logic [3:0]  cfg_div = '0;
    logic [7:0]  cfg_ext = '0;
    logic [31:0] tx_data = '0;
    logic        miso = 1'b0;
    logic        sclk, mosi, cs_n, rx_valid, busy;
    logic [31:0] rx_data;

    int checks = 0;
    int errors = 0;
    localparam int WATCHDOG = 190000;

    always #2.5 clk = ~clk;

    spi_master_chan uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_wlen(cfg_wlen),
        .cfg_mode(cfg_mode), .cfg_guard(cfg_guard), .cfg_lin(cfg_lin),
        .cfg_div(cfg_div), .cfg_ext(cfg_ext), .tx_data(tx_data), .miso(miso),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .rx_data(rx_data),
        .rx_valid(rx_valid), .busy(busy)
    );

    // slave model and edge monitor, all at the falling reference edge
    int          cyc = 0;
    int          cur_w = 8;
    logic [31:0] pat = '0;
    logic        prev_cs = 1'b1, prev_sclk = 1'b0, prev_busy = 1'b0;
    int          t_csfall, t_rise1, t_lastfall, t_csrise, t_idle;
    int          rises = 0, vcount = 0, cs_falls = 0, bit_i = 0;
    logic [31:0] cap = '0, vdata = '0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (prev_cs && !cs_n) begin
            t_csfall = cyc; rises = 0; cap = '0; vcount = 0;
            cs_falls = cs_falls + 1;
            bit_i = cur_w - 1;
            miso = pat[bit_i];
        end
        if (!prev_sclk && sclk) begin
            if (rises == 0) t_rise1 = cyc;
            cap = {cap[30:0], mosi};
            rises = rises + 1;
        end
        if (prev_sclk && !sclk) begin
            t_lastfall = cyc;
            if (bit_i > 0) begin
                bit_i = bit_i - 1;
                miso = pat[bit_i];
            end
        end
        if (!prev_cs && cs_n) t_csrise = cyc;
        if (prev_busy && !busy) t_idle = cyc;
        if (rx_valid) begin
            vcount = vcount + 1;
            vdata = rx_data;
        end
        prev_cs = cs_n; prev_sclk = sclk; prev_busy = busy;
        if (cyc > WATCHDOG) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_xfer(input int wc, input int md, input int g, input int lin,
                            input int dv, input int ex, input logic [31:0] txw,
                            input logic [31:0] pw, input bit poke);
        int w, h, n, limit, base;
        logic [31:0] mask;
        string dtag;
        w = wc + 1;
        h = lin ? (((ex << 4) | dv) + 1) : (1 << dv);
        dtag = lin ? "R6" : "R5";
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        cur_w = w; pat = pw;
        base = cs_falls;
        @(negedge clk);
        cfg_wlen = 5'(wc); cfg_mode = 2'(md); cfg_guard = 2'(g); cfg_lin = 1'(lin);
        cfg_div = 4'(dv); cfg_ext = 8'(ex); tx_data = txw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 busy after start", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            cfg_wlen = 5'd4; cfg_mode = 2'd1; cfg_guard = 2'd0; cfg_div = 4'd0;
            tx_data = ~txw; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        limit = (2 * (2 * g + 1) + 2 * w + 4) * h + 40;
        n = 0;
        while (busy && n < limit) begin
            @(negedge clk);
            n = n + 1;
        end
        @(negedge clk);
        chk("R11 transfer completes", busy, 0);
        chk("R1 rising edge count", rises, w);
        chk("R10 one frame per start", cs_falls - base, 1);
        if (md == 1) chk("R8 mosi low", cap, 0);
        else         chk("R7 mosi word MSB first", cap, txw & mask);
        chk({"R3 lead guard ", dtag}, t_rise1 - t_csfall, (2 * g + 1) * h);
        chk({"R4 trail guard ", dtag}, t_csrise - t_lastfall, (2 * g + 1) * h);
        chk("R10 chip-select recovery", t_idle - t_csrise, 2 * h);
        if (md == 2) begin
            chk("R9 no valid in transmit only", vcount, 0);
        end else begin
            chk("R7 single valid pulse", vcount, 1);
            chk("R7 received word", vdata, pw & mask);
        end
    endtask

    task automatic run_reserved(input int wc, input int md);
        int base;
        base = cs_falls;
        @(negedge clk);
        cfg_wlen = 5'(wc); cfg_mode = 2'(md); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy stays low", busy, 0);
        repeat (10) @(negedge clk);
        chk("R2 no chip select", cs_falls - base, 0);
        chk("R2 cs high", cs_n, 1);
    endtask

    initial begin
        int seed;
        logic [31:0] tw, pw;
        repeat (3) @(negedge clk);
        chk("R12 cs_n reset", cs_n, 1);
        chk("R12 sclk reset", sclk, 0);
        chk("R12 mosi reset", mosi, 0);
        chk("R12 busy reset", busy, 0);
        chk("R12 rx_valid reset", rx_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: reserved length codes and reserved mode
        for (int wc = 0; wc < 3; wc++) run_reserved(wc, 0);
        run_reserved(7, 3);

        // R1, R3, R4, R7..R9: full sweep at divide ratio 1
        seed = 1;
        for (int md = 0; md < 3; md++) begin
            for (int g = 0; g < 4; g++) begin
                for (int wc = 3; wc < 32; wc++) begin
                    tw = 32'h6B3C_A5D2 ^ (32'(seed) * 32'h9E37_79B9);
                    pw = {tw[15:0], tw[31:16]} ^ 32'h5A5A_0F0F;
                    run_xfer(wc, md, g, 0, 0, 0, tw, pw, 1'b0);
                    seed++;
                end
            end
        end

        // R5: power-of-two divider codes
        for (int dv = 1; dv < 7; dv++) begin
            run_xfer(7, 0, 1, 0, dv, 0, 32'h0000_00C5 + 32'(dv), 32'h0000_003A, 1'b0);
        end

        // R6: linear divider including the extension bits
        run_xfer(5, 0, 2, 1, 0, 0, 32'h0000_002D, 32'h0000_0013, 1'b0);
        run_xfer(5, 1, 2, 1, 2, 0, 32'h0000_002D, 32'h0000_0031, 1'b0);
        run_xfer(5, 2, 0, 1, 9, 0, 32'h0000_0017, 32'h0000_0000, 1'b0);
        run_xfer(6, 0, 3, 1, 3, 1, 32'h0000_0055, 32'h0000_006A, 1'b0);

        // R10: start and new configuration during a running transfer
        run_xfer(15, 0, 1, 0, 1, 0, 32'h0000_BEEF, 32'h0000_1234, 1'b1);
        run_xfer(31, 2, 2, 1, 1, 0, 32'hC001_D00D, 32'h0, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule